// File: doc/BRIEF.md
# Sprite/Background Pattern Bank Selector

This block sits on the cartridge side of a tile-based video generator. It maps the generator's 13-bit pattern address onto a wider pattern-memory address. The CPU loads two banks of 1 KB bank numbers. The "sprite" bank holds eight slots that cover the full 8 KB pattern space. The "background" bank holds four slots that cover 4 KB. The block also snoops CPU writes to the video control register, so it knows whether sprites are 8 or 16 pixels tall.

When sprites are 16 pixels tall and rendering is active, the block follows the video generator's dot counter. During the horizontal-blank window, where the next line's sprite patterns are fetched, it translates through the sprite bank. At every other dot it translates through the background bank. The switch therefore happens twice per scanline with no help from the CPU. When sprites are 8 pixels tall, or when rendering is idle, whichever bank the CPU loaded most recently serves every fetch. The translated address is the selected 8-bit bank number joined to the low ten bits of the pattern address.

Top module: `chr_bank_mapper`

## Requirements
- R1: After reset every bank slot holds 0, the sprite-height mode is 8x8 and the most recently loaded bank is the sprite bank, so `ext_addr` equals `{8'h00, pat_addr[9:0]}`.
- R2: A CPU write to 0x5120+i (i = 0..7) stores the data byte as the bank number of sprite-bank slot i. Slot i serves pattern addresses whose bits [12:10] equal i. The write marks the sprite bank as most recently loaded.
- R3: A CPU write to 0x512B+j (j = 0..3) stores the data byte as the bank number of background-bank slot j. Slot j serves pattern addresses whose bits [11:10] equal j. The write marks the background bank as most recently loaded.
- R4: While the background bank is selected, bit 12 of `pat_addr` has no effect on `ext_addr`, so 0x1000–0x1FFF mirrors 0x0000–0x0FFF.
- R5: A CPU write to 0x2000 sets the sprite-height mode from data bit 5, where 1 means 8x16 and 0 means 8x8. The other data bits are ignored.
- R6: In 8x16 mode with rendering active, dots 256 through 319 inclusive are translated through the sprite bank.
- R7: In 8x16 mode with rendering active, dots outside 256..319 are translated through the background bank.
- R8: In 8x8 mode, every dot is translated through the most recently loaded bank.
- R9: Rendering is active only when `render_en` is 1 and `line` is below 240 or equal to 261. When rendering is not active, the most recently loaded bank is used in either mode.
- R10: `ext_addr[9:0]` always equals `pat_addr[9:0]`.
- R11: CPU writes to any other address, including 0x5128–0x512A and 0x512F, change no bank slot, no mode and no record of the last loaded bank.
- R12: In 8x16 mode with rendering active, one pass of `dot` from 0 to 340 across a line changes the selected bank exactly twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| render_en | input | 1 | Rendering enabled by the video generator |
| line | input | 9 | Current scanline, 0..261 |
| dot | input | 9 | Current dot within the scanline, 0..340 |
| pat_addr | input | 13 | Pattern address issued by the video generator |
| ext_addr | output | 18 | Translated pattern-memory address, {bank, offset} |

## Verification
A bank-slot write is visible on `ext_addr` one rising edge after the write is sampled. A change of `dot`, `line`, `render_en`, sprite mode or last-loaded bank moves the bank choice one edge after it is sampled, because the choice is registered. `pat_addr` acts on `ext_addr` combinationally. The bench drives every input on the falling edge. It completes a write before it presents a lookup. It then lets one rising edge pass and samples 1 ns later, when both the registered bank choice and the combinational translation have settled.

// File: rtl/chr_map_pkg.sv
// Package chr_map_pkg
// Shared widths and the bank-set encoding for the pattern bank selector.
// Assumes 1 KB bank granularity and an 8 KB pattern space.
package chr_map_pkg;
    localparam int BANK_W  = 8;   // bank number width
    localparam int OFS_W   = 10;  // offset within a 1 KB bank
    localparam int A_SLOTS = 8;   // slots of the sprite bank set
    localparam int B_SLOTS = 4;   // slots of the background bank set
    localparam int DOT_W   = 9;
    localparam int LINE_W  = 9;
    localparam int PAT_W   = OFS_W + $clog2(A_SLOTS);
    localparam int EXT_W   = BANK_W + OFS_W;

    typedef enum logic {SET_A = 1'b0, SET_B = 1'b1} chr_set_e;
endpackage

// File: rtl/chr_bank_regs.sv
// Module chr_bank_regs
// Holds both bank register sets, the snooped sprite-height mode and the
// record of which set the CPU loaded last. Assumes a single-cycle write
// strobe with address and data valid in the same cycle.
module chr_bank_regs
    import chr_map_pkg::*;
#(
    parameter logic [15:0] A_BASE    = 16'h5120,
    parameter logic [15:0] B_BASE    = 16'h512B,
    parameter logic [15:0] CTRL_ADDR = 16'h2000,
    parameter int          SPR_BIT   = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cpu_we,
    input  logic [15:0]                      cpu_addr,
    input  logic [7:0]                       cpu_wdata,
    output logic [A_SLOTS-1:0][BANK_W-1:0]   bank_a,
    output logic [B_SLOTS-1:0][BANK_W-1:0]   bank_b,
    output logic                             tall_mode,
    output chr_set_e                         last_set
);
    logic [A_SLOTS-1:0] a_hit;
    logic [B_SLOTS-1:0] b_hit;
    logic               ctrl_hit;

    assign ctrl_hit = cpu_we && (cpu_addr == CTRL_ADDR);

    for (genvar i = 0; i < A_SLOTS; i++) begin : g_a
        logic [BANK_W-1:0] slot_q;
        assign a_hit[i] = cpu_we && (cpu_addr == 16'(A_BASE + i));
        // Load sprite slot i on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)        slot_q <= '0;
            else if (a_hit[i]) slot_q <= cpu_wdata[BANK_W-1:0];
        end
        assign bank_a[i] = slot_q;
    end

    for (genvar j = 0; j < B_SLOTS; j++) begin : g_b
        logic [BANK_W-1:0] slot_q;
        assign b_hit[j] = cpu_we && (cpu_addr == 16'(B_BASE + j));
        // Load background slot j on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)        slot_q <= '0;
            else if (b_hit[j]) slot_q <= cpu_wdata[BANK_W-1:0];
        end
        assign bank_b[j] = slot_q;
    end

    // Record which set received the most recent write.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_set <= SET_A;
        else if (|a_hit) last_set <= SET_A;
        else if (|b_hit) last_set <= SET_B;
    end

    // Snoop the sprite-height bit from control register writes.
    always_ff @(posedge clk) begin
        if (!rst_n)        tall_mode <= 1'b0;
        else if (ctrl_hit) tall_mode <= cpu_wdata[SPR_BIT];
    end

    // R2: a write inside the sprite range leaves the sprite set marked as last loaded
    a_r2_last_a: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr >= A_BASE && cpu_addr < A_BASE + 16'(A_SLOTS)) |=> (last_set == SET_A));
    // R3: a write inside the background range marks the background set
    a_r3_last_b: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr >= B_BASE && cpu_addr < B_BASE + 16'(B_SLOTS)) |=> (last_set == SET_B));
    // R5: the mode follows bit 5 of a control write
    a_r5_mode_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == CTRL_ADDR) |=> (tall_mode == $past(cpu_wdata[SPR_BIT])));
    // R11: with no write nothing held here may move
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_we |=> ($stable(bank_a) && $stable(bank_b) && $stable(last_set) && $stable(tall_mode)));
endmodule

// File: rtl/chr_fetch_phase.sv
// Module chr_fetch_phase
// Decides, once per dot, which bank set translates the next fetch.
// The choice is registered so that it holds for the whole dot. Assumes one
// clock per dot and that the dot/line inputs come from the video generator.
module chr_fetch_phase
    import chr_map_pkg::*;
#(
    parameter int WIN_LO    = 256,
    parameter int WIN_HI    = 319,
    parameter int VIS_LINES = 240,
    parameter int PRE_LINE  = 261
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DOT_W-1:0]  dot,
    input  logic [LINE_W-1:0] line,
    input  logic              render_en,
    input  logic              tall_mode,
    input  chr_set_e          last_set,
    output chr_set_e          sel_q
);
    logic     render_live;
    logic     in_win;
    chr_set_e sel_d;

    // Classify the current dot and line.
    always_comb begin
        render_live = render_en &&
                      ((line < LINE_W'(VIS_LINES)) || (line == LINE_W'(PRE_LINE)));
        in_win      = (dot >= DOT_W'(WIN_LO)) && (dot <= DOT_W'(WIN_HI));
    end

    // Pick the set: the split applies only to tall sprites while rendering.
    always_comb begin
        if (render_live && tall_mode) sel_d = in_win ? SET_A : SET_B;
        else                          sel_d = last_set;
    end

    // Register the choice on the dot boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= SET_A;
        else        sel_q <= sel_d;
    end

    // R6: sprite window on a rendered line selects the sprite set
    a_r6_sprite_win: assert property (@(posedge clk) disable iff (!rst_n)
        (render_en && tall_mode && line == LINE_W'(PRE_LINE) && dot == DOT_W'(WIN_LO))
        |=> (sel_q == SET_A));
    // R7: the first dot after the window returns to the background set
    a_r7_bg_after: assert property (@(posedge clk) disable iff (!rst_n)
        (render_en && tall_mode && line == '0 && dot == DOT_W'(WIN_HI + 1))
        |=> (sel_q == SET_B));
    // R8: in short-sprite mode the last loaded set always wins
    a_r8_short_last: assert property (@(posedge clk) disable iff (!rst_n)
        !tall_mode |=> (sel_q == $past(last_set)));
    // R9: with rendering off the last loaded set always wins
    a_r9_idle_last: assert property (@(posedge clk) disable iff (!rst_n)
        !render_en |=> (sel_q == $past(last_set)));
endmodule

// File: rtl/chr_addr_xlate.sv
// Module chr_addr_xlate
// Combinational translation of a pattern address through the selected set.
// The background set ignores the top pattern address bit, so its upper
// half mirrors the lower half.
module chr_addr_xlate
    import chr_map_pkg::*;
(
    input  chr_set_e                        sel,
    input  logic [A_SLOTS-1:0][BANK_W-1:0]  bank_a,
    input  logic [B_SLOTS-1:0][BANK_W-1:0]  bank_b,
    input  logic [PAT_W-1:0]                pat_addr,
    output logic [EXT_W-1:0]                ext_addr
);
    localparam int A_IDX_W = $clog2(A_SLOTS);
    localparam int B_IDX_W = $clog2(B_SLOTS);

    logic [A_IDX_W-1:0] a_idx;
    logic [B_IDX_W-1:0] b_idx;
    logic [BANK_W-1:0]  bank;

    // Slot indices from the upper pattern address bits.
    always_comb begin
        a_idx = pat_addr[OFS_W +: A_IDX_W];
        b_idx = pat_addr[OFS_W +: B_IDX_W];
    end

    // Select the bank number and join it with the in-bank offset.
    always_comb begin
        bank     = (sel == SET_A) ? bank_a[a_idx] : bank_b[b_idx];
        ext_addr = {bank, pat_addr[OFS_W-1:0]};
    end
endmodule

// File: rtl/chr_bank_mapper.sv
// Module chr_bank_mapper (top)
// Pattern bank selector: register sets, mode snoop, fetch-phase choice and
// address translation. Assumes one clock per video dot.
module chr_bank_mapper
    import chr_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              render_en,
    input  logic [LINE_W-1:0] line,
    input  logic [DOT_W-1:0]  dot,
    input  logic [PAT_W-1:0]  pat_addr,
    output logic [EXT_W-1:0]  ext_addr
);
    logic [A_SLOTS-1:0][BANK_W-1:0] bank_a;
    logic [B_SLOTS-1:0][BANK_W-1:0] bank_b;
    logic                           tall_mode;
    chr_set_e                       last_set;
    chr_set_e                       sel_q;

    chr_bank_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .bank_a    (bank_a),
        .bank_b    (bank_b),
        .tall_mode (tall_mode),
        .last_set  (last_set)
    );

    chr_fetch_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .dot       (dot),
        .line      (line),
        .render_en (render_en),
        .tall_mode (tall_mode),
        .last_set  (last_set),
        .sel_q     (sel_q)
    );

    chr_addr_xlate u_xlate (
        .sel      (sel_q),
        .bank_a   (bank_a),
        .bank_b   (bank_b),
        .pat_addr (pat_addr),
        .ext_addr (ext_addr)
    );
endmodule

// File: tb/chr_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module chr_bank_mapper_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        render_en = 1'b0;
    logic [8:0]  line = '0;
    logic [8:0]  dot = '0;
    logic [12:0] pat_addr = '0;
    logic [17:0] ext_addr;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    logic [7:0] m_a [8];
    logic [7:0] m_b [4];
    bit         m_tall;
    bit         m_last_b;

    always #2 clk = ~clk;

    chr_bank_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .render_en(render_en), .line(line),
        .dot(dot), .pat_addr(pat_addr), .ext_addr(ext_addr)
    );

    function automatic logic [17:0] exp_addr(logic [12:0] a, logic [8:0] d,
                                             logic [8:0] l, bit ren);
        bit live = ren && (l < 240 || l == 261);
        bit use_b;
        if (live && m_tall) use_b = !(d >= 256 && d <= 319);
        else                use_b = m_last_b;
        return use_b ? {m_b[a[11:10]], a[9:0]} : {m_a[a[12:10]], a[9:0]};
    endfunction

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
        if (a >= 16'h5120 && a <= 16'h5127) begin m_a[a[2:0]] = d; m_last_b = 0; end
        else if (a >= 16'h512B && a <= 16'h512E) begin m_b[a - 16'h512B] = d; m_last_b = 1; end
        else if (a == 16'h2000) m_tall = d[5];
    endtask

    task automatic look(input string tag, input logic [12:0] a, input logic [8:0] d,
                        input logic [8:0] l, input bit ren);
        logic [17:0] e;
        @(negedge clk);
        pat_addr = a; dot = d; line = l; render_en = ren;
        @(posedge clk); #1;
        e = exp_addr(a, d, l, ren);
        n_chk++;
        if (ext_addr !== e) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (addr %h dot %0d line %0d ren %0d)",
                     tag, ext_addr, e, a, d, l, ren);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [17:0] prev;
        int          sw;
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < 8; i++) m_a[i] = 0;
        for (int j = 0; j < 4; j++) m_b[j] = 0;
        m_tall = 0; m_last_b = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        look("R1 reset", 13'h1ABC, 9'd10, 9'd5, 1'b1);
        look("R1 reset", 13'h0123, 9'd300, 9'd5, 1'b1);

        // R2 each sprite slot, R10 offset pass-through
        for (int i = 0; i < 8; i++) wr(16'h5120 + 16'(i), 8'(8'hA0 + i));
        for (int i = 0; i < 8; i++) look("R2 slot", {3'(i), 10'h2C5}, 9'd0, 9'd0, 1'b0);
        look("R10 offset", 13'h13FF, 9'd5, 9'd5, 1'b0);

        // R3 background slots, R4 mirror
        for (int j = 0; j < 4; j++) wr(16'h512B + 16'(j), 8'(8'h50 + j));
        for (int j = 0; j < 4; j++) look("R3 slot", {1'b0, 2'(j), 10'h011}, 9'd0, 9'd0, 1'b0);
        look("R4 mirror hi", 13'h1C22, 9'd0, 9'd0, 1'b0);
        look("R4 mirror hi", 13'h1422, 9'd100, 9'd100, 1'b1);

        // R11 ignored addresses
        wr(16'h5128, 8'hEE); wr(16'h512A, 8'hEE); wr(16'h512F, 8'hEE); wr(16'h2001, 8'hFF);
        look("R11 ignored", 13'h0C00, 9'd0, 9'd0, 1'b0);
        look("R11 ignored", 13'h1C00, 9'd300, 9'd5, 1'b1);

        // R5 mode with only bit 5; R6/R7 window boundaries
        wr(16'h2000, 8'h20);
        look("R7 dot255", 13'h1400, 9'd255, 9'd5, 1'b1);
        look("R6 dot256", 13'h1400, 9'd256, 9'd5, 1'b1);
        look("R6 dot319", 13'h1400, 9'd319, 9'd261, 1'b1);
        look("R7 dot320", 13'h1400, 9'd320, 9'd261, 1'b1);
        // R9 idle line and render off
        look("R9 line240", 13'h1400, 9'd300, 9'd240, 1'b1);
        look("R9 line260", 13'h1400, 9'd10, 9'd260, 1'b1);
        look("R9 off", 13'h1400, 9'd300, 9'd5, 1'b0);
        wr(16'h5121, 8'h77);
        look("R9 off lastA", 13'h0400, 9'd10, 9'd5, 1'b0);
        // R8 short sprites use last set everywhere
        wr(16'h2000, 8'hDF);
        look("R8 short win", 13'h0400, 9'd300, 9'd5, 1'b1);
        wr(16'h512C, 8'h33);
        look("R8 short lastB", 13'h1400, 9'd300, 9'd5, 1'b1);
        look("R8 short lastB", 13'h1400, 9'd10, 9'd5, 1'b1);

        // R12 sweep one line, expect exactly two switches
        wr(16'h2000, 8'h20);
        sw = 0;
        look("R12 sweep", 13'h0000, 9'd0, 9'd7, 1'b1);
        prev = ext_addr;
        for (int d = 1; d <= 340; d++) begin
            look("R12 sweep", 13'h0000, 9'(d), 9'd7, 1'b1);
            if (ext_addr != prev) sw++;
            prev = ext_addr;
        end
        n_chk++;
        if (sw != 2) begin
            n_fail++;
            $display("FAIL R12 switches: got %0d expected 2", sw);
        end

        // Random mix of writes and lookups
        for (int k = 0; k < 600; k++) begin
            int c = $urandom_range(0, 9);
            if (c == 0) wr(16'h5120 + 16'($urandom_range(0, 7)), 8'($urandom));
            else if (c == 1) wr(16'h512B + 16'($urandom_range(0, 3)), 8'($urandom));
            else if (c == 2) wr(16'h2000, 8'($urandom));
            else if (c == 3) wr(16'h5120 + 16'($urandom_range(8, 15)) & 16'hFFFF, 8'($urandom));
            else look("R6 R7 R8 R9 random", 13'($urandom), 9'($urandom_range(0, 340)),
                      9'($urandom_range(0, 261)), bit'($urandom_range(0, 1)));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule